// File: doc/BRIEF.md
# Board Interrupt Expander

The block merges sixteen interrupt sources from a board into one active-high, level-sensitive request line for a host processor. Each source passes through a two-flop synchroniser. A rising edge of the synchronised level sets a latched pending bit. This happens whether or not the source is enabled.

An enable vector decides which pending bits reach the output. Software changes it through two addresses: one where a written 1 turns an enable on, and one where a written 1 turns it off. The request line stays high as long as any pending bit is also enabled. To find the cause, software reads the pending word and scans the enabled bits upward from bit 0. It then writes ones back to the pending word to retire them. A separate read-only view shows the synchronised input levels.

By board convention, line 8 carries the Ethernet controller, line 10 the first external UART and line 11 the second.

Top module: `irq_expander`

## Requirements
- R1: After reset the enable vector and every pending bit are 0, and `irq_o` is 0.
- R2: A 0-to-1 change on `src_i[i]` sets pending bit i three clock edges later, whether or not line i is enabled. A source held high does not set the bit again once it has been cleared.
- R3: A write to byte offset 0x1A sets each enable bit whose data bit is 1 and leaves every other enable bit unchanged. A read of 0x1A returns the enable vector.
- R4: A write to byte offset 0x1C clears each enable bit whose data bit is 1 and leaves every other enable bit unchanged. A read of 0x1C also returns the enable vector.
- R5: A read of byte offset 0x16 returns the pending vector. A write there clears each pending bit whose data bit is 1, so 0xFFFF retires every pending bit.
- R6: A read of byte offset 0x18 returns the synchronised source levels and changes no state. Writes to 0x18 are ignored.
- R7: `irq_o` is 1 exactly when the bitwise AND of the pending and enable vectors is non-zero. It follows a register change in the same cycle.
- R8: If a rising edge of line i and a write clearing pending bit i fall in the same cycle, bit i stays set.
- R9: `bus_rdata` is loaded at the clock edge that samples `bus_rd` and holds its value until the next read. A read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 16 | Asynchronous interrupt source lines |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_o | output | 1 | Level-sensitive interrupt request to the host |

## Verification
A source change is driven on a falling edge. It appears in the raw view after the second rising edge and in the pending vector after the third. The bench therefore waits three falling edges before it reads either one.

A register write takes effect at the single rising edge under its strobe, and `irq_o` is sampled on the falling edge after that edge. Read data is loaded at the edge that samples the strobe and is checked on the following falling edge.

The collision case is timed so that the clearing write lands on the exact edge where the new rising edge is captured.

// File: rtl/irqx_pkg.sv
// Package: register offsets and board source assignments for the interrupt
// expander. Assumes an 8-bit byte-offset bus address.
package irqx_pkg;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_PENDING = 8'h16;
    localparam logic [ADDR_W-1:0] OFS_RAW     = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_EN_SET  = 8'h1A;
    localparam logic [ADDR_W-1:0] OFS_EN_CLR  = 8'h1C;

    localparam int LINE_ETH   = 8;
    localparam int LINE_UARTA = 10;
    localparam int LINE_UARTB = 11;
endpackage

// File: rtl/irqx_capture.sv
// Module: per-line two-flop synchroniser and rising-edge detector.
// Assumes the source lines are asynchronous to clk. The synchronised level
// and a one-cycle rise pulse are produced for each line.
module irqx_capture #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] rise_o
);
    for (genvar g = 0; g < N; g++) begin : g_line
        logic meta_q, sync_q, prev_q;

        // Purpose: move the line into the clk domain and remember the last level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= src_i[g];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign level_o[g] = sync_q;
        assign rise_o[g]  = sync_q & ~prev_q;
    end
endmodule

// File: rtl/irqx_regs.sv
// Module: register file for the expander. It holds the enable vector, with
// separate set and clear addresses, and the pending vector, which is
// write-one-to-clear. It also provides the registered read port. Assumes
// single-cycle strobes and that a new rise beats a clear of the same bit.
module irqx_regs
    import irqx_pkg::*;
#(
    parameter int N = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [N-1:0]      wdata_i,
    input  logic [N-1:0]      rise_i,
    input  logic [N-1:0]      level_i,
    output logic [N-1:0]      rdata_o,
    output logic [N-1:0]      en_o,
    output logic [N-1:0]      pend_o
);
    logic [N-1:0] en_q, pend_q, rdata_q, rd_mux;
    logic         wr_set, wr_clr, wr_pend;

    assign wr_set  = wr_i && (addr_i == OFS_EN_SET);
    assign wr_clr  = wr_i && (addr_i == OFS_EN_CLR);
    assign wr_pend = wr_i && (addr_i == OFS_PENDING);

    // Purpose: update the enable vector from the set and clear addresses.
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= '0;
        else if (wr_set) en_q <= en_q | wdata_i;
        else if (wr_clr) en_q <= en_q & ~wdata_i;
    end

    // Purpose: latch rises and retire bits written with one (a rise wins).
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~(wr_pend ? wdata_i : '0)) | rise_i;
    end

    // Purpose: select the word for the addressed register.
    always_comb begin
        unique case (addr_i)
            OFS_PENDING: rd_mux = pend_q;
            OFS_RAW:     rd_mux = level_i;
            OFS_EN_SET:  rd_mux = en_q;
            OFS_EN_CLR:  rd_mux = en_q;
            default:     rd_mux = '0;
        endcase
    end

    // Purpose: load the read data on a read strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)    rdata_q <= '0;
        else if (rd_i) rdata_q <= rd_mux;
    end

    assign rdata_o = rdata_q;
    assign en_o    = en_q;
    assign pend_o  = pend_q;

    a_r3_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((en_q & $past(wdata_i)) == $past(wdata_i)));
    a_r4_clr_takes: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((en_q & $past(wdata_i)) == '0));
    a_r3_en_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_set || wr_clr) |=> $stable(en_q));
    a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pend |=> ((pend_q & $past(wdata_i) & ~$past(rise_i)) == '0));
    a_r8_rise_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(rise_i)) == $past(rise_i)));
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(rise_i)) == '0));
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_q));
endmodule

// File: rtl/irq_expander.sv
// Module: top of the board interrupt expander. Sixteen source lines are
// captured on rising edges into pending bits, gated by an enable vector, and
// ORed onto one active-high level request. Assumes a simple strobe bus.
module irq_expander
    import irqx_pkg::*;
#(
    parameter int N = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      src_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [N-1:0]      bus_wdata,
    output logic [N-1:0]      bus_rdata,
    output logic              irq_o
);
    logic [N-1:0] level, rise, en, pend;

    irqx_capture #(.N(N)) u_cap (
        .clk(clk), .rst_n(rst_n), .src_i(src_i),
        .level_o(level), .rise_o(rise)
    );

    irqx_regs #(.N(N)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .rd_i(bus_rd),
        .addr_i(bus_addr), .wdata_i(bus_wdata), .rise_i(rise),
        .level_i(level), .rdata_o(bus_rdata), .en_o(en), .pend_o(pend)
    );

    // Purpose: request while any enabled pending bit remains.
    assign irq_o = |(pend & en);

    a_r7_quiet_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !irq_o);
    a_r7_quiet_no_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> !irq_o);
endmodule

// File: tb/irq_expander_test.sv
module irq_expander_test;
    import irqx_pkg::*;

    localparam logic [3:0] K_WR = 4'd0, K_RD = 4'd1, K_SRC = 4'd2, K_IRQ = 4'd3;
    // entry: {kind, requirement, offset, data-or-expected}
    localparam int NV = 30;
    localparam logic [31:0] VEC [NV] = '{
        {K_RD,  4'd1, OFS_EN_SET,  16'h0000},  // R1 enables clear
        {K_RD,  4'd1, OFS_PENDING, 16'h0000},  // R1 nothing pending
        {K_IRQ, 4'd1, 8'h00,       16'h0000},  // R1 request low
        {K_WR,  4'd3, OFS_EN_SET,  16'h0D00},  // enable lines 8,10,11
        {K_RD,  4'd3, OFS_EN_SET,  16'h0D00},  // R3
        {K_WR,  4'd3, OFS_EN_SET,  16'h0000},  // zeros change nothing
        {K_RD,  4'd4, OFS_EN_CLR,  16'h0D00},  // R3/R4 read via clear address
        {K_SRC, 4'd2, 8'h00,       16'h0100},  // line 8 rises
        {K_RD,  4'd2, OFS_PENDING, 16'h0100},  // R2
        {K_RD,  4'd6, OFS_RAW,     16'h0100},  // R6
        {K_IRQ, 4'd7, 8'h00,       16'h0001},  // R7
        {K_WR,  4'd5, OFS_PENDING, 16'h0100},  // retire line 8, still high
        {K_RD,  4'd5, OFS_PENDING, 16'h0000},  // R5 and R2 no re-set on level
        {K_IRQ, 4'd7, 8'h00,       16'h0000},
        {K_SRC, 4'd2, 8'h00,       16'h0020},  // line 8 drops, line 5 rises
        {K_RD,  4'd2, OFS_PENDING, 16'h0020},  // R2 latched though disabled
        {K_IRQ, 4'd7, 8'h00,       16'h0000},  // R7 masked
        {K_WR,  4'd3, OFS_EN_SET,  16'h0020},
        {K_IRQ, 4'd7, 8'h00,       16'h0001},
        {K_WR,  4'd4, OFS_EN_CLR,  16'h0020},
        {K_IRQ, 4'd4, 8'h00,       16'h0000},  // R4
        {K_RD,  4'd4, OFS_EN_SET,  16'h0D00},  // R4 others kept
        {K_SRC, 4'd2, 8'h00,       16'h0C20},  // lines 10,11 rise
        {K_RD,  4'd2, OFS_PENDING, 16'h0C20},
        {K_WR,  4'd5, OFS_PENDING, 16'h0400},
        {K_RD,  4'd5, OFS_PENDING, 16'h0820},  // R5 single bit
        {K_WR,  4'd5, OFS_PENDING, 16'hFFFF},
        {K_RD,  4'd5, OFS_PENDING, 16'h0000},  // R5 all
        {K_WR,  4'd6, OFS_RAW,     16'hFFFF},  // R6 write ignored
        {K_RD,  4'd6, OFS_RAW,     16'h0C20}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       src = '0;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr = 1'b0, rd = 1'b0;
    logic [15:0]       wdata = '0;
    logic [15:0]       rdata;
    logic              irq;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_expander uut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(addr),
        .bus_wr(wr), .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(rdata),
        .irq_o(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk); rd = 1'b1; addr = a;
        @(negedge clk); rd = 1'b0; d = rdata;
    endtask

    task automatic drive_src(input logic [15:0] v);
        @(negedge clk); src = v;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            logic [3:0] k;
            string tag;
            k = VEC[i][31:28];
            tag = $sformatf("R%0d step %0d", VEC[i][27:24], i);
            case (k)
                K_WR:  bus_write(VEC[i][23:16], VEC[i][15:0]);
                K_RD:  begin bus_read(VEC[i][23:16], r); check(tag, r, VEC[i][15:0]); end
                K_SRC: drive_src(VEC[i][15:0]);
                default: begin @(negedge clk); check(tag, {15'd0, irq}, VEC[i][15:0]); end
            endcase
        end

        // R9: unmapped offset reads 0; data holds without a read strobe
        bus_read(8'h00, r);
        check("R9 unmapped", r, 16'h0000);
        bus_read(OFS_EN_SET, r);
        repeat (3) @(negedge clk);
        check("R9 hold", rdata, 16'h0D00);

        // R8: line 0 rises on the edge where its clear is written
        @(negedge clk); src[0] = 1'b1;
        @(negedge clk);
        bus_write(OFS_PENDING, 16'h0001);
        bus_read(OFS_PENDING, r);
        check("R8 rise beats clear", r, 16'h0001);
        bus_write(OFS_PENDING, 16'h0001);
        bus_read(OFS_PENDING, r);
        check("R8 plain clear", r, 16'h0000);

        // R1: reset mid-run returns to the idle state
        bus_write(OFS_EN_SET, 16'h0001);
        @(negedge clk); src = '0; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 irq in reset", {15'd0, irq}, 16'h0000);
        rst_n = 1'b1;
        bus_read(OFS_EN_CLR, r);
        check("R1 enables after reset", r, 16'h0000);
        bus_read(OFS_PENDING, r);
        check("R1 pending after reset", r, 16'h0000);

        // R2/R7: Ethernet line through the full path after re-enabling
        bus_write(OFS_EN_SET, 16'h0001 << LINE_ETH);
        drive_src(16'h0001 << LINE_ETH);
        check("R7 ethernet request", {15'd0, irq}, 16'h0001);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule